// File: doc/BRIEF.md
# DDR2 SDRAM Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to its first usable state. It holds the clock enable and on-die termination low until the supplies are reported stable. It then waits the mandated settling time and walks a fixed list of commands on the command, bank and address pins. These are precharge of all banks, enabling the DLL, resetting the DLL while programming the operating mode, a second precharge-all, a parameterized number of auto-refreshes, a mode write that clears the DLL-reset bit, and the off-chip-driver default setting. After that it raises a done flag so the normal controller can take the pins.

Every wait is a cycle count, given by a parameter whose default comes from the clock period. There is no data interface: the pins are plain control outputs, and `pwr_stable` is a level input with no handshake. An active-low asynchronous reset restarts the whole sequence at any time.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is low, and until CKE rises, CKE=0, ODT=0 and {cs_n,ras_n,cas_n,we_n}=4'b1111 (deselect). ODT stays 0 at all times.
- R2: CKE rises, together with one NOP (4'b0111), at the T_PWRUP-th consecutive clock edge that samples `pwr_stable` high. A low sample restarts the count. CKE then stays high until reset.
- R3: Command codes on {cs_n,ras_n,cas_n,we_n} are: precharge 4'b0010, auto-refresh 4'b0001, mode/extended-mode write 4'b0000, NOP 4'b0111. Each command lasts one cycle, and every other cycle after CKE rises is a NOP.
- R4: The first precharge-all (addr=14'h0400, only A10 set; ba=0) comes T_RFC cycles after the CKE/NOP edge.
- R5: T_RP cycles later, a DLL-enable extended mode write is issued with ba=2'b01 and addr=0.
- R6: T_MRD cycles later, a DLL-reset mode write is issued with ba=2'b00 and addr=MR_OPS with bit 8 forced to 1.
- R7: T_MRD cycles later, a second precharge-all (as in R4) is issued. T_RP cycles after it comes the first of N_REF auto-refreshes (ba=0, addr=0), and the refreshes are spaced T_RFC cycles apart.
- R8: T_RFC cycles after the last refresh, a mode write is issued with ba=2'b00 and addr=MR_OPS with bit 8 forced to 0.
- R9: T_MRD cycles later, an extended mode write for the driver default is issued with ba=2'b01 and addr=14'h0380 (bits 9, 8 and 7 set).
- R10: `init_done` rises at edge max(O+T_MRD, D+T_DLLK), where O is the R9 edge and D the R6 edge. It then stays high, with CKE high and only NOPs on the command pins.
- R11: Asserting reset at any point returns all outputs to the R1 state with `init_done`=0, and the full sequence restarts after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supplies and clock reported stable |
| cke | output | 1 | Clock enable to the memory |
| odt | output | 1 | On-die termination, held low |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 14 | Row/mode address |
| init_done | output | 1 | Sequence complete, controller may take over |

## Verification
All outputs are registered, so each result appears one edge after the condition that triggers it. The CKE edge is the T_PWRUP-th stable sample. Each later command is a fixed gap after the one before it, and the done flag is due at the later of the two R10 edges. The bench computes every due edge from the edge at which it drove `pwr_stable` or released reset. It samples at the falling clock edge and compares the number of edges seen with the due edge for each command, the CKE rise and the done rise. A power glitch and a reset in mid-sequence shift those due edges, and the bench checks that shift too.

// File: rtl/ddr2i_pkg.sv
`timescale 1ns/1ps
package ddr2i_pkg;
  localparam int ADDR_W = 14;
  localparam int BA_W   = 2;
  localparam int BIT_ALLBANK = 10;
  localparam int BIT_DLLRST  = 8;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_DES = 4'b1111
  } cmd_e;

  typedef enum logic [3:0] {
    PH_PWR, PH_PREA1, PH_EMRS_DLL, PH_MRS_RST, PH_PREA2,
    PH_REF, PH_MRS_RUN, PH_EMRS_OCD, PH_DONE
  } phase_e;

  typedef struct packed {
    cmd_e              cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
  } pin_s;

  localparam pin_s PINS_DES = '{cmd: CMD_DES, ba: '0, addr: '0};
  localparam pin_s PINS_NOP = '{cmd: CMD_NOP, ba: '0, addr: '0};
endpackage

// File: rtl/ddr2i_gap_timer.sv
`timescale 1ns/1ps
module ddr2i_gap_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  AST_GAP_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("gap"); // R3
endmodule

// File: rtl/ddr2i_lock_window.sv
`timescale 1ns/1ps
module ddr2i_lock_window #(
  parameter int T_DLLK = 200,
  localparam int W = $clog2(T_DLLK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic open
);
  logic [W-1:0] cnt_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= W'(T_DLLK - 1);
      armed_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open = armed_q && (cnt_q == '0);

  AST_LOCK_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (open && !start) |=> open) else $error("lock"); // R10
endmodule

// File: rtl/ddr2i_step_rom.sv
`timescale 1ns/1ps
module ddr2i_step_rom
  import ddr2i_pkg::*;
#(
  parameter int GAP_W = 5,
  parameter int T_RFC = 14,
  parameter int T_RP  = 2,
  parameter int T_MRD = 2,
  parameter logic [ADDR_W-1:0] MR_OPS = 14'h0242
) (
  input  phase_e           phase,
  output pin_s             step,
  output logic [GAP_W-1:0] gap_m1
);
  localparam logic [ADDR_W-1:0] A_ALLBANK = ADDR_W'(1) << BIT_ALLBANK;
  localparam logic [ADDR_W-1:0] A_DLLRST  = ADDR_W'(1) << BIT_DLLRST;
  localparam logic [ADDR_W-1:0] A_OCDDEF  = ADDR_W'(7) << 7;

  always_comb begin
    step   = PINS_NOP;
    gap_m1 = GAP_W'(T_RFC - 1);
    unique case (phase)
      PH_PWR: begin
        step   = PINS_NOP;
        gap_m1 = GAP_W'(T_RFC - 1);
      end
      PH_PREA1, PH_PREA2: begin
        step   = '{cmd: CMD_PRE, ba: '0, addr: A_ALLBANK};
        gap_m1 = GAP_W'(T_RP - 1);
      end
      PH_EMRS_DLL: begin
        step   = '{cmd: CMD_MRS, ba: 2'b01, addr: '0};
        gap_m1 = GAP_W'(T_MRD - 1);
      end
      PH_MRS_RST: begin
        step   = '{cmd: CMD_MRS, ba: 2'b00, addr: MR_OPS | A_DLLRST};
        gap_m1 = GAP_W'(T_MRD - 1);
      end
      PH_REF: begin
        step   = '{cmd: CMD_REF, ba: '0, addr: '0};
        gap_m1 = GAP_W'(T_RFC - 1);
      end
      PH_MRS_RUN: begin
        step   = '{cmd: CMD_MRS, ba: 2'b00, addr: MR_OPS & ~A_DLLRST};
        gap_m1 = GAP_W'(T_MRD - 1);
      end
      PH_EMRS_OCD: begin
        step   = '{cmd: CMD_MRS, ba: 2'b01, addr: A_OCDDEF};
        gap_m1 = GAP_W'(T_MRD - 1);
      end
      default: begin
        step   = PINS_NOP;
        gap_m1 = '0;
      end
    endcase
  end
endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
module ddr2_init_seq
  import ddr2i_pkg::*;
#(
  parameter int CLK_PS  = 8000,
  parameter int T_PWRUP = (200_000_000 + CLK_PS - 1) / CLK_PS,
  parameter int T_RFC   = (105_000 + CLK_PS - 1) / CLK_PS,
  parameter int T_RP    = (15_000 + CLK_PS - 1) / CLK_PS,
  parameter int T_MRD   = 2,
  parameter int T_DLLK  = 200,
  parameter int N_REF   = 2,
  parameter logic [13:0] MR_OPS = 14'h0242
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_stable,
  output logic        cke,
  output logic        odt,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [1:0]  ba,
  output logic [13:0] addr,
  output logic        init_done
);
  localparam int PU_W  = $clog2(T_PWRUP + 1);
  localparam int GAP_W = $clog2(T_RFC + T_RP + T_MRD + 1);
  localparam int REF_W = $clog2(N_REF + 1);

  phase_e            phase_q, next_phase;
  pin_s              pin_q, step;
  logic [PU_W-1:0]   pu_cnt_q;
  logic [REF_W-1:0]  ref_cnt_q;
  logic [GAP_W-1:0]  gap_m1;
  logic              cke_q, done_q;
  logic              gap_busy, gap_load, dll_open, dll_start;
  logic              pu_fire, last_ref, issuing;

  ddr2i_step_rom #(
    .GAP_W(GAP_W), .T_RFC(T_RFC), .T_RP(T_RP), .T_MRD(T_MRD), .MR_OPS(MR_OPS)
  ) u_rom (
    .phase(phase_q), .step(step), .gap_m1(gap_m1)
  );

  ddr2i_gap_timer #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_m1), .busy(gap_busy)
  );

  ddr2i_lock_window #(.T_DLLK(T_DLLK)) u_lock (
    .clk(clk), .rst_n(rst_n), .start(dll_start), .open(dll_open)
  );

  assign pu_fire   = (phase_q == PH_PWR) && pwr_stable && (pu_cnt_q == PU_W'(T_PWRUP - 1));
  assign last_ref  = (ref_cnt_q == REF_W'(N_REF - 1));
  assign issuing   = (phase_q != PH_PWR) && (phase_q != PH_DONE) && !gap_busy;
  assign gap_load  = pu_fire || issuing;
  assign dll_start = issuing && (phase_q == PH_MRS_RST);

  always_comb begin
    unique case (phase_q)
      PH_PWR:      next_phase = PH_PREA1;
      PH_PREA1:    next_phase = PH_EMRS_DLL;
      PH_EMRS_DLL: next_phase = PH_MRS_RST;
      PH_MRS_RST:  next_phase = PH_PREA2;
      PH_PREA2:    next_phase = PH_REF;
      PH_REF:      next_phase = last_ref ? PH_MRS_RUN : PH_REF;
      PH_MRS_RUN:  next_phase = PH_EMRS_OCD;
      PH_EMRS_OCD: next_phase = PH_DONE;
      default:     next_phase = PH_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_PWR;
      pin_q     <= PINS_DES;
      pu_cnt_q  <= '0;
      ref_cnt_q <= '0;
      cke_q     <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_PWR: begin
          pin_q <= PINS_DES;
          if (!pwr_stable) begin
            pu_cnt_q <= '0;
          end else if (pu_fire) begin
            cke_q   <= 1'b1;
            pin_q   <= step;
            phase_q <= next_phase;
          end else begin
            pu_cnt_q <= pu_cnt_q + 1'b1;
          end
        end
        PH_DONE: begin
          pin_q <= PINS_NOP;
          if (!gap_busy && dll_open) done_q <= 1'b1;
        end
        default: begin
          if (gap_busy) begin
            pin_q <= PINS_NOP;
          end else begin
            pin_q   <= step;
            phase_q <= next_phase;
            if (phase_q == PH_REF)
              ref_cnt_q <= last_ref ? '0 : ref_cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign cke       = cke_q;
  assign odt       = 1'b0;
  assign {cs_n, ras_n, cas_n, we_n} = pin_q.cmd;
  assign ba        = pin_q.ba;
  assign addr      = pin_q.addr;
  assign init_done = done_q;

  AST_DESELECT_BEFORE_CKE: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == 4'b1111)) else $error("des"); // R1
  AST_CKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke) else $error("cke"); // R2
  AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && ({ras_n, cas_n, we_n} != 3'b111)) |=> ({ras_n, cas_n, we_n} == 3'b111)) else $error("one"); // R3
  AST_PREA_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> addr[BIT_ALLBANK]) else $error("prea"); // R4
  AST_MODE_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0000) |-> !ba[1]) else $error("mrs"); // R5
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done) else $error("done"); // R10
  AST_DONE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> dll_open) else $error("lock"); // R10
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111) && cke) else $error("quiet"); // R10
endmodule

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;
  localparam int TP = 30, TRFC = 6, TRP = 3, TMRD = 2, TDLL = 60, NREF = 3;
  localparam logic [13:0] OPS = 14'h0243;

  logic clk = 1'b0, rst_n = 1'b0, pwr_stable = 1'b0;
  logic cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [13:0] addr;

  ddr2_init_seq #(.T_PWRUP(TP), .T_RFC(TRFC), .T_RP(TRP), .T_MRD(TMRD),
                  .T_DLLK(TDLL), .N_REF(NREF), .MR_OPS(OPS)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable), .cke(cke), .odt(odt),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba),
    .addr(addr), .init_done(init_done));

  always #4 clk = ~clk;

  typedef struct {
    int          cyc;
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [13:0] addr;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  int exp_cke = -1, exp_done = -1, exp_d = 0;
  logic cke_d = 1'b0, done_d = 1'b0;
  logic [3:0] cv;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  task automatic push(input int c, input logic [3:0] k, input logic [1:0] b,
                      input logic [13:0] a, input string r);
    exp_t e;
    e.cyc = c; e.cmd = k; e.ba = b; e.addr = a; e.req = r;
    exp_q.push_back(e);
  endtask

  // Driver: expected schedule from the edge that first samples stable power.
  task automatic plan(input int e0);
    int t, o;
    exp_cke = e0 + TP - 1;
    t = exp_cke + TRFC;  push(t, 4'b0010, 2'b00, 14'h0400, "R4");
    t += TRP;            push(t, 4'b0000, 2'b01, 14'h0000, "R5");
    t += TMRD;           push(t, 4'b0000, 2'b00, OPS | 14'h0100, "R6");
    exp_d = t;
    t += TMRD;           push(t, 4'b0010, 2'b00, 14'h0400, "R7");
    t += TRP;
    for (int i = 0; i < NREF; i++) begin
      push(t, 4'b0001, 2'b00, 14'h0000, "R7");
      t += TRFC;
    end
                         push(t, 4'b0000, 2'b00, OPS & ~14'h0100, "R8");
    t += TMRD;           push(t, 4'b0000, 2'b01, 14'h0380, "R9");
    o = t;
    exp_done = (o + TMRD > exp_d + TDLL) ? o + TMRD : exp_d + TDLL;
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // Monitor
  always @(negedge clk) begin
    cv = {cs_n, ras_n, cas_n, we_n};
    chk(odt == 1'b0, "R1", "odt", odt, 0);
    if (!rst_n) begin
      chk(!cke && cv == 4'b1111 && !init_done, "R11", "reset pins {cke,cmd,done}",
          {cke, cv, init_done}, 6'b011110);
    end else begin
      if (!cke) chk(cv == 4'b1111, "R1", "deselect before cke", cv, 4'b1111);
      if (cke && !cke_d) begin
        chk(cyc == exp_cke, "R2", "cke rise edge", cyc, exp_cke);
        chk(cv == 4'b0111, "R2", "nop with cke", cv, 4'b0111);
      end
      if (cv != 4'b0111 && cv != 4'b1111) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected command", cv, 4'b0111);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.cyc, e.req, "command edge", cyc, e.cyc);
          chk(cv == e.cmd, e.req, "command code", cv, e.cmd);
          chk(ba == e.ba, e.req, "bank", ba, e.ba);
          chk(addr == e.addr, e.req, "address", addr, e.addr);
        end
      end
      if (init_done && !done_d)
        chk(cyc == exp_done, "R10", "done rise edge", cyc, exp_done);
    end
    cke_d  = cke;
    done_d = init_done;
  end

  task automatic finish_run(input string tag);
    while (cyc < exp_done + 20) tick(1);
    chk(exp_q.size() == 0, "R10", {tag, " items left"}, exp_q.size(), 0);
    chk(init_done && cke, "R10", {tag, " done and cke"}, {init_done, cke}, 2'b11);
  endtask

  initial begin
    tick(3);
    chk(!cke && !init_done, "R11", "held in reset", {cke, init_done}, 0);
    rst_n = 1'b1;
    tick(8);
    chk(!cke, "R1", "cke low without power", cke, 0);
    // Run 1: power glitch restarts the settle count (R2)
    pwr_stable = 1'b1;
    tick(10);
    pwr_stable = 1'b0;
    tick(4);
    chk(!cke, "R2", "cke low after glitch", cke, 0);
    pwr_stable = 1'b1;
    plan(cyc + 1);
    finish_run("run1");
    // Run 2: reset after done, power already stable, then reset mid-sequence (R11)
    rst_n = 1'b0;
    tick(2);
    chk(!init_done && !cke, "R11", "reset clears done", {init_done, cke}, 0);
    rst_n = 1'b1;
    plan(cyc + 1);
    while (cyc < exp_d + 5) tick(1);
    rst_n = 1'b0;
    exp_q.delete();
    exp_cke = -1; exp_done = -1;
    tick(3);
    chk(!cke && {cs_n, ras_n, cas_n, we_n} == 4'b1111, "R11", "mid-sequence reset",
        {cke, cs_n, ras_n, cas_n, we_n}, 5'b01111);
    rst_n = 1'b1;
    plan(cyc + 1);
    finish_run("run3");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule